// File: doc/BRIEF.md
# Three-Phase Complementary PWM Timer

This block drives three complementary PWM pairs from a single up-counter. The counter counts from zero up to a period compare value `m`, then restarts at zero, so one PWM period is `m+1` count ticks. Each channel compares the counter against its own duty value `n`. The normal-phase pin is active above `n` and the counter-phase pin is active at or below it. A separate toggle pin inverts once per period, which marks the period boundaries for external logic.

The counter advances on a count tick. The tick comes from the system clock divided by 1, 2, 4, 8 or 32, or from an edge of an external clock pin, with the edge selectable. Software-style inputs do the following:

- start and stop the count, either at once or at the end of the current period;
- write the counter;
- choose the active and initial level of each pin;
- clear sticky event flags for period match, duty match and overflow.

A cutoff input forces all six phase pins inactive. They stay inactive until a latched cutoff flag is cleared.

Top module: `pwm3_timer`

## Requirements
- R1: While counting, each tick advances the counter by one. A tick at which the counter equals `period_i` returns it to 0 instead. The counter therefore covers 0..m, and the period is m+1 ticks.
- R2: For channel k with duty value n, the normal-phase pin (pwm_o[2k]) is active when the counter is greater than n. The counter-phase pin (pwm_o[2k+1]) is active when the counter is at most n. Over one period this gives m−n and n+1 ticks. When n ≥ m, the normal-phase pin is never active.
- R3: A pin is at level act_lvl_i[i] when active and at the inverse level when inactive. From reset until the first start, each pin shows init_lvl_i[i].
- R4: tog_o is 0 after reset and inverts on every return of the counter to 0 from `period_i`.
- R5: src_sel_i picks the tick source: 0 is every clock, 1 is every 2nd clock, 2 is every 4th, 3 is every 8th, 4 is every 32nd, and 5 is the external pin.
- R6: With src_sel_i = 5, a rising edge of ext_clk_i counts when ext_fall_i = 0 and a falling edge counts when ext_fall_i = 1. The counter changes on the third clock edge after the pin changes, and the other edge is ignored.
- R7: A rising edge of start_i starts counting. With stop_at_match_i = 0, a low start_i stops the count at the next clock edge, and the counter and pins hold their levels.
- R8: With stop_at_match_i = 1, counting ends at the first period match after a start, even if start_i stays high. The counter rests at 0 and the pins keep the levels set by that match.
- R9: A counter write (cnt_wr_i) loads cnt_wdata_i at the next tick after the edge that sampled it, whether or not the counter is running. cnt_o always shows the counter.
- R10: The sticky flags behave as follows. irq_period_o sets on a period match. irq_duty_o[k] sets on a counting tick taken while the counter equals duty k. irq_ovf_o sets when the counter wraps from all ones without a period match. Each flag clears on its irq_clr_i bit (bit 0 period, bits 1..3 duty, bit 4 overflow), and a set in the same cycle wins over the clear.
- R11: cutoff_i sampled high sets cut_o. From the next cycle all six pins are at their inactive levels while counting continues. cutoff_clr_i clears cut_o if cutoff_i is low, and the pins then follow the counter again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 3 | Tick source select |
| ext_clk_i | input | 1 | External count clock pin |
| ext_fall_i | input | 1 | External clock counts on its falling edge when 1 |
| start_i | input | 1 | Count enable; its rising edge starts the count |
| stop_at_match_i | input | 1 | 1: stop at the period match; 0: stop as soon as start_i is low |
| period_i | input | CNT_W | Period compare value m |
| duty_i | input | N_CH*CNT_W | Duty compare values, channel k at bits k*CNT_W |
| act_lvl_i | input | 2*N_CH | Active level of each pin |
| init_lvl_i | input | 2*N_CH | Pin level before the first start |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write value |
| cnt_o | output | CNT_W | Counter readback |
| pwm_o | output | 2*N_CH | Phase pins: 2k normal, 2k+1 counter phase |
| tog_o | output | 1 | Per-period toggle pin |
| irq_period_o | output | 1 | Period match flag |
| irq_duty_o | output | N_CH | Duty match flags |
| irq_ovf_o | output | 1 | Overflow flag |
| irq_clr_i | input | N_CH+2 | Flag clear strobes |
| cutoff_i | input | 1 | Forced cutoff request |
| cutoff_clr_i | input | 1 | Clears the latched cutoff |
| cut_o | output | 1 | Latched cutoff flag |

## Verification
The bench builds the block with CNT_W = 4 and N_CH = 3. At that width every period value from 1 to 15 can be swept against a full range of duty values, with two whole periods per setting, in a few thousand cycles. This includes duty values equal to or above the period. The short counter also puts the overflow wrap within a few ticks of a write above the period. It also lets the slowest divider and the external clock source be timed across whole periods.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  typedef enum logic [2:0] {
    SRC_DIV1  = 3'd0,
    SRC_DIV2  = 3'd1,
    SRC_DIV4  = 3'd2,
    SRC_DIV8  = 3'd3,
    SRC_DIV32 = 3'd4,
    SRC_EXT   = 3'd5
  } src_sel_e;

  localparam int unsigned PRE_W = 5;  // log2 of the largest divider
endpackage

// File: rtl/pwm3_tick_gen.sv
module pwm3_tick_gen
  import pwm3_pkg::*;
#(
  parameter int unsigned SYNC_W = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_sel_i,
  input  logic       ext_clk_i,
  input  logic       ext_fall_i,
  output logic       tick_o
);
  logic [PRE_W-1:0]  pre_q;
  logic [SYNC_W-1:0] sync_q;
  logic              ext_prev_q;
  logic              ext_s;
  logic              ext_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q      <= '0;
      sync_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      pre_q      <= pre_q + 1'b1;
      sync_q     <= {sync_q[SYNC_W-2:0], ext_clk_i};
      ext_prev_q <= sync_q[SYNC_W-1];
    end
  end

  assign ext_s    = sync_q[SYNC_W-1];
  assign ext_tick = ext_fall_i ? (~ext_s & ext_prev_q) : (ext_s & ~ext_prev_q);

  always_comb begin
    unique case (src_sel_e'(src_sel_i))
      SRC_DIV1:  tick_o = 1'b1;
      SRC_DIV2:  tick_o = pre_q[0];
      SRC_DIV4:  tick_o = &pre_q[1:0];
      SRC_DIV8:  tick_o = &pre_q[2:0];
      SRC_DIV32: tick_o = &pre_q[4:0];
      SRC_EXT:   tick_o = ext_tick;
      default:   tick_o = 1'b0;
    endcase
  end

  // R6: an external tick needs the synchronized level to have moved
  p_ext_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == SRC_EXT && tick_o) |-> (sync_q[SYNC_W-1] != ext_prev_q));
endmodule

// File: rtl/pwm3_count_ctl.sv
module pwm3_count_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_at_match_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             step_o,
  output logic             cmp_en_o,
  output logic             load_o,
  output logic             wrap_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, wval_q, cnt_d;
  logic             start_q, run_q, pend_q;
  logic             start_rise, cnt_en, step, match;

  assign start_rise = start_i & ~start_q;
  assign cnt_en     = run_q & (start_i | stop_at_match_i);
  assign step       = tick_i & cnt_en;
  assign match      = (cnt_q == period_i);
  assign cmp_en_o   = step & ~pend_q;
  assign wrap_o     = cmp_en_o & match;
  assign ovf_o      = cmp_en_o & ~match & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i && pend_q) cnt_d = wval_q;
    else if (step)        cnt_d = match ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      wval_q  <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      start_q <= start_i;
      if (wr_i) begin
        pend_q <= 1'b1;
        wval_q <= wdata_i;
      end else if (tick_i) begin
        pend_q <= 1'b0;
      end
      if (start_rise)                         run_q <= 1'b1;
      else if (!stop_at_match_i && !start_i)  run_q <= 1'b0;
      else if (wrap_o && stop_at_match_i)     run_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign cnt_d_o = cnt_d;
  assign step_o  = step;
  assign load_o  = start_rise;

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !pend_q && !wr_i) |=> $stable(cnt_o));
  p_match_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && stop_at_match_i && !start_rise) |=> !step_o);
  p_ovf_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0));
endmodule

// File: rtl/pwm3_phase_chan.sv
module pwm3_phase_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [1:0]       act_o,    // [0] normal, [1] counter phase
  output logic             match_o
);
  logic [1:0] ph_q;

  function automatic logic [1:0] phase_of(input logic [CNT_W-1:0] c,
                                          input logic [CNT_W-1:0] n);
    return {c <= n, c > n};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= 2'b10;
    else if (step_i)  ph_q <= phase_of(cnt_d_i, duty_i);
    else if (load_i)  ph_q <= phase_of(cnt_q_i, duty_i);
  end

  assign act_o   = ph_q;
  assign match_o = cmp_en_i & (cnt_q_i == duty_i);

  p_norm_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && duty_i < period_i) |=> (act_o == 2'b01));
  p_ctr_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_d_i == '0) |=> (act_o == 2'b10));
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_CH  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2:0]            src_sel_i,
  input  logic                  ext_clk_i,
  input  logic                  ext_fall_i,
  input  logic                  start_i,
  input  logic                  stop_at_match_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [N_CH*CNT_W-1:0] duty_i,
  input  logic [2*N_CH-1:0]     act_lvl_i,
  input  logic [2*N_CH-1:0]     init_lvl_i,
  input  logic                  cnt_wr_i,
  input  logic [CNT_W-1:0]      cnt_wdata_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic [2*N_CH-1:0]     pwm_o,
  output logic                  tog_o,
  output logic                  irq_period_o,
  output logic [N_CH-1:0]       irq_duty_o,
  output logic                  irq_ovf_o,
  input  logic [N_CH+1:0]       irq_clr_i,
  input  logic                  cutoff_i,
  input  logic                  cutoff_clr_i,
  output logic                  cut_o
);
  localparam int unsigned N_OUT = 2 * N_CH;
  localparam int unsigned N_FLG = N_CH + 2;

  logic             tick, step, cmp_en, load, wrap, ovf;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       ch_act [N_CH];
  logic [N_CH-1:0]  ch_match;
  logic [N_FLG-1:0] flg_q, flg_set;
  logic [N_OUT-1:0] pin_raw;
  logic             tog_q, cut_q, armed_q;

  pwm3_tick_gen #(.SYNC_W(2)) u_tick (
    .clk_i, .rst_ni, .src_sel_i, .ext_clk_i, .ext_fall_i, .tick_o(tick)
  );

  pwm3_count_ctl #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .start_i, .stop_at_match_i, .period_i,
    .wr_i(cnt_wr_i), .wdata_i(cnt_wdata_i), .cnt_o(cnt_q), .cnt_d_o(cnt_d),
    .step_o(step), .cmp_en_o(cmp_en), .load_o(load), .wrap_o(wrap), .ovf_o(ovf)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pwm3_phase_chan #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .step_i(step), .load_i(load), .cmp_en_i(cmp_en),
      .cnt_q_i(cnt_q), .cnt_d_i(cnt_d), .duty_i(duty_i[g*CNT_W +: CNT_W]),
      .period_i, .act_o(ch_act[g]), .match_o(ch_match[g])
    );
  end

  always_comb begin
    for (int k = 0; k < N_CH; k++) begin
      for (int p = 0; p < 2; p++) begin
        if (!armed_q)          pin_raw[2*k+p] = init_lvl_i[2*k+p];
        else if (ch_act[k][p]) pin_raw[2*k+p] = act_lvl_i[2*k+p];
        else                   pin_raw[2*k+p] = ~act_lvl_i[2*k+p];
      end
    end
  end

  assign flg_set = {ovf, ch_match, wrap};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q   <= '0;
      tog_q   <= 1'b0;
      cut_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flg_q <= flg_set | (flg_q & ~irq_clr_i);
      if (wrap) tog_q <= ~tog_q;
      if (cutoff_i)          cut_q <= 1'b1;
      else if (cutoff_clr_i) cut_q <= 1'b0;
      if (load) armed_q <= 1'b1;
    end
  end

  assign cnt_o        = cnt_q;
  assign pwm_o        = cut_q ? ~act_lvl_i : pin_raw;
  assign tog_o        = tog_q;
  assign irq_period_o = flg_q[0];
  assign irq_duty_o   = flg_q[N_CH:1];
  assign irq_ovf_o    = flg_q[N_CH+1];
  assign cut_o        = cut_q;

  p_tog_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (tog_o != $past(tog_o)));
  p_cut_safe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cutoff_i && rst_ni) |-> (pwm_o == ~act_lvl_i));
  p_period_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_period_o) |-> $past(wrap));
endmodule

// File: tb/tb_pwm3_timer.sv
`timescale 1ns/1ps
module tb_pwm3_timer;
  localparam int W = 4;
  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [2:0]     src_sel_i = 3'd0;
  logic           ext_fall_i = 1'b0;
  logic           start_i = 1'b0;
  logic           stop_at_match_i = 1'b0;
  logic [W-1:0]   period_i = '0;
  logic [N*W-1:0] duty_i = '0;
  logic [2*N-1:0] act_lvl_i = '0;
  logic [2*N-1:0] init_lvl_i = 6'b101100;
  logic           cnt_wr_i = 1'b0;
  logic [W-1:0]   cnt_wdata_i = '0;
  logic [N+1:0]   irq_clr_i = '0;
  logic           cutoff_i = 1'b0;
  logic           cutoff_clr_i = 1'b0;
  logic [W-1:0]   cnt_o;
  logic [2*N-1:0] pwm_o;
  logic           tog_o, irq_period_o, irq_ovf_o, cut_o;
  logic [N-1:0]   irq_duty_o;

  logic ext_on = 1'b0;
  logic ext_man = 1'b0;
  int   ext_ph = 0;
  logic ext_clk_i;
  assign ext_clk_i = ext_on ? (ext_ph < 2) : ext_man;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  pwm3_timer #(.CNT_W(W), .N_CH(N)) dut (
    .clk_i(clk), .rst_ni, .src_sel_i, .ext_clk_i, .ext_fall_i, .start_i,
    .stop_at_match_i, .period_i, .duty_i, .act_lvl_i, .init_lvl_i, .cnt_wr_i,
    .cnt_wdata_i, .cnt_o, .pwm_o, .tog_o, .irq_period_o, .irq_duty_o,
    .irq_ovf_o, .irq_clr_i, .cutoff_i, .cutoff_clr_i, .cut_o
  );

  initial forever begin
    @(negedge clk);
    if (ext_on) ext_ph = (ext_ph + 1) % 6;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2*N-1:0] exp_pins(input int c, input logic [2*N-1:0] act,
                                              input logic [N*W-1:0] d);
    logic [2*N-1:0] p;
    for (int k = 0; k < N; k++) begin
      bit norm;
      norm = c > int'(d[k*W +: W]);
      p[2*k]   = norm ? act[2*k] : ~act[2*k];
      p[2*k+1] = norm ? ~act[2*k+1] : act[2*k+1];
    end
    return p;
  endfunction

  task automatic wr_cnt(input int v);
    cnt_wr_i = 1'b1; cnt_wdata_i = W'(v);
    cyc(1);
    cnt_wr_i = 1'b0;
    cyc(1);
  endtask

  task automatic clr_flags();
    irq_clr_i = '1; cyc(1); irq_clr_i = '0;
  endtask

  task automatic meas(output int iv);
    logic t0;
    int k;
    t0 = tog_o; k = 0;
    while (tog_o == t0 && k < 3000) begin cyc(1); k++; end
    t0 = tog_o; k = 0;
    while (tog_o == t0 && k < 3000) begin cyc(1); k++; end
    iv = k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int iv, c0, c1;
    logic [2*N-1:0] p0;
    logic t0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    // reset state
    chk(cnt_o == 0, "R1 reset count", int'(cnt_o), 0);
    chk(pwm_o == init_lvl_i, "R3 initial levels", int'(pwm_o), int'(init_lvl_i));
    chk(tog_o == 1'b0, "R4 toggle reset", int'(tog_o), 0);
    chk({irq_period_o, irq_duty_o, irq_ovf_o, cut_o} == '0, "R10 flags reset",
        int'({irq_period_o, irq_duty_o, irq_ovf_o, cut_o}), 0);

    // period and duty sweep at divide by one
    for (int m = 1; m < 16; m++) begin
      for (int s = 0; s < 16; s++) begin
        int mism, over, tg;
        int nc [N];
        int cc [N];
        logic tp;
        start_i = 1'b0;
        cyc(1);
        wr_cnt(0);
        period_i = W'(m);
        duty_i = {W'((3*s+1) % 16), W'((s+5) % 16), W'(s)};
        act_lvl_i = 6'((m*7 + s*5) & 63);
        start_i = 1'b1;
        cyc(2);
        mism = 0; over = 0; tg = 0; tp = tog_o;
        for (int k = 0; k < N; k++) begin nc[k] = 0; cc[k] = 0; end
        for (int i = 0; i < 2*(m+1); i++) begin
          cyc(1);
          if (pwm_o != exp_pins(int'(cnt_o), act_lvl_i, duty_i)) mism++;
          if (int'(cnt_o) > m) over++;
          if (tog_o != tp) begin tg++; tp = tog_o; end
          for (int k = 0; k < N; k++) begin
            if (pwm_o[2*k] == act_lvl_i[2*k]) nc[k]++;
            if (pwm_o[2*k+1] == act_lvl_i[2*k+1]) cc[k]++;
          end
        end
        chk(mism == 0, "R2 R3 pin pattern vs count", mism, 0);
        chk(over == 0, "R1 count within period", over, 0);
        chk(tg == 2, "R4 toggles per two periods", tg, 2);
        for (int k = 0; k < N; k++) begin
          int n, ne;
          n = int'(duty_i[k*W +: W]);
          ne = (n < m) ? 2*(m-n) : 0;
          chk(nc[k] == ne, "R2 normal-phase width", nc[k], ne);
          chk(cc[k] == 2*(m+1) - ne, "R2 counter-phase width", cc[k], 2*(m+1) - ne);
        end
      end
    end

    // R5 dividers, period m=3
    period_i = 4'd3;
    for (int sel = 0; sel < 5; sel++) begin
      int dv;
      dv = (sel == 4) ? 32 : (1 << sel);
      src_sel_i = 3'(sel);
      meas(iv);
      meas(iv);
      chk(iv == 4*dv, "R5 tick divider", iv, 4*dv);
    end

    // R6 external clock, both edges, period 6 clocks
    src_sel_i = 3'd5;
    ext_on = 1'b1;
    for (int e = 0; e < 2; e++) begin
      ext_fall_i = 1'(e);
      meas(iv);
      meas(iv);
      chk(iv == 24, "R6 external tick period", iv, 24);
    end
    ext_on = 1'b0; ext_man = 1'b0; ext_fall_i = 1'b0;
    period_i = 4'd15;
    cyc(6);
    c0 = int'(cnt_o);
    ext_man = 1'b1;
    cyc(2);
    chk(int'(cnt_o) == c0, "R6 no count before third edge", int'(cnt_o), c0);
    cyc(1);
    chk(int'(cnt_o) == (c0+1) % 16, "R6 rising edge counted", int'(cnt_o), (c0+1) % 16);
    ext_man = 1'b0;
    cyc(5);
    chk(int'(cnt_o) == (c0+1) % 16, "R6 falling edge ignored", int'(cnt_o), (c0+1) % 16);
    ext_fall_i = 1'b1;
    ext_man = 1'b1;
    cyc(5);
    chk(int'(cnt_o) == (c0+1) % 16, "R6 rising ignored in falling mode", int'(cnt_o), (c0+1) % 16);
    ext_man = 1'b0;
    cyc(3);
    chk(int'(cnt_o) == (c0+2) % 16, "R6 falling edge counted", int'(cnt_o), (c0+2) % 16);
    ext_fall_i = 1'b0;

    // R7 immediate stop and restart
    src_sel_i = 3'd0;
    period_i = 4'd9;
    duty_i = {4'd7, 4'd4, 4'd1};
    start_i = 1'b0; cyc(1); start_i = 1'b1;
    cyc(7);
    start_i = 1'b0;
    c0 = int'(cnt_o); p0 = pwm_o;
    cyc(1);
    chk(int'(cnt_o) == c0, "R7 count holds after stop", int'(cnt_o), c0);
    cyc(5);
    chk(int'(cnt_o) == c0, "R7 count still held", int'(cnt_o), c0);
    chk(pwm_o == p0, "R7 pins hold after stop", int'(pwm_o), int'(p0));
    start_i = 1'b1;
    cyc(1);
    chk(int'(cnt_o) == c0, "R7 no count on start edge", int'(cnt_o), c0);
    cyc(1);
    c1 = (c0 == 9) ? 0 : c0 + 1;
    chk(int'(cnt_o) == c1, "R7 count resumes", int'(cnt_o), c1);

    // R9 counter write
    start_i = 1'b0;
    cyc(2);
    c0 = int'(cnt_o);
    cnt_wr_i = 1'b1; cnt_wdata_i = 4'd11;
    cyc(1);
    cnt_wr_i = 1'b0;
    chk(int'(cnt_o) == c0, "R9 write pending until tick", int'(cnt_o), c0);
    cyc(1);
    chk(cnt_o == 4'd11, "R9 write loaded at next tick", int'(cnt_o), 11);
    src_sel_i = 3'd3;
    cnt_wr_i = 1'b1; cnt_wdata_i = 4'd3;
    cyc(1);
    cnt_wr_i = 1'b0;
    cyc(10);
    chk(cnt_o == 4'd3, "R9 write loaded at divided tick", int'(cnt_o), 3);
    src_sel_i = 3'd0;

    // R8 stop at match, R10 flags
    wr_cnt(0);
    period_i = 4'd5;
    duty_i = {4'd7, 4'd2, 4'd1};
    stop_at_match_i = 1'b1;
    clr_flags();
    cyc(1);
    chk({irq_period_o, irq_duty_o, irq_ovf_o} == '0, "R10 flags cleared",
        int'({irq_period_o, irq_duty_o, irq_ovf_o}), 0);
    t0 = tog_o; iv = 0;
    start_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      logic tq;
      tq = tog_o;
      cyc(1);
      if (tog_o != tq) iv++;
    end
    chk(cnt_o == 0, "R8 rests at zero", int'(cnt_o), 0);
    chk(iv == 1, "R8 single period", iv, 1);
    chk(pwm_o == exp_pins(0, act_lvl_i, duty_i), "R8 pins after match",
        int'(pwm_o), int'(exp_pins(0, act_lvl_i, duty_i)));
    chk(irq_period_o == 1'b1, "R10 period flag", int'(irq_period_o), 1);
    chk(irq_duty_o == 3'b011, "R10 duty flags", int'(irq_duty_o), 3);
    chk(irq_ovf_o == 1'b0, "R10 no overflow", int'(irq_ovf_o), 0);
    cyc(10);
    chk(cnt_o == 0, "R8 stays stopped with start high", int'(cnt_o), 0);
    clr_flags();
    cyc(1);
    chk({irq_period_o, irq_duty_o, irq_ovf_o} == '0, "R10 clear after stop",
        int'({irq_period_o, irq_duty_o, irq_ovf_o}), 0);
    stop_at_match_i = 1'b0;
    start_i = 1'b0;

    // R10 overflow
    cyc(1);
    start_i = 1'b1;
    cyc(3);
    clr_flags();
    chk(irq_ovf_o == 1'b0, "R10 overflow clear", int'(irq_ovf_o), 0);
    wr_cnt(12);
    cyc(6);
    chk(irq_ovf_o == 1'b1, "R10 overflow flag", int'(irq_ovf_o), 1);
    chk(int'(cnt_o) <= 5, "R1 count back in period", int'(cnt_o), 5);

    // R11 cutoff
    period_i = 4'd9;
    act_lvl_i = 6'b011010;
    cyc(3);
    cutoff_i = 1'b1;
    cyc(1);
    cutoff_i = 1'b0;
    chk(cut_o == 1'b1, "R11 cutoff latched", int'(cut_o), 1);
    chk(pwm_o == ~act_lvl_i, "R11 pins inactive", int'(pwm_o), int'(~act_lvl_i));
    c0 = int'(cnt_o);
    cyc(5);
    chk(pwm_o == ~act_lvl_i, "R11 pins stay inactive", int'(pwm_o), int'(~act_lvl_i));
    chk(int'(cnt_o) != c0, "R11 count keeps running", int'(cnt_o), (c0+5) % 10);
    cutoff_clr_i = 1'b1;
    cyc(1);
    cutoff_clr_i = 1'b0;
    chk(cut_o == 1'b0, "R11 cutoff cleared", int'(cut_o), 0);
    chk(pwm_o == exp_pins(int'(cnt_o), act_lvl_i, duty_i), "R11 pins resume",
        int'(pwm_o), int'(exp_pins(int'(cnt_o), act_lvl_i, duty_i)));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule